// File: doc/BRIEF.md
# Shadow RAM Region Decoder

This block decides, for every CPU memory access in the upper-memory window between 0xC0000 and 0xFFFFF, whether the access is served by on-board DRAM, passed to the external bus (boot ROM or an adapter card), or, for writes, silently dropped. Firmware sets this up through a small bank of eight-bit configuration registers. It reaches them in I/O space: it first writes an index to one port and then reads or writes the chosen register through a second port.

The window is cut into eight 16 KB segments from 0xC0000 to 0xDFFFF and two 64 KB regions at 0xE0000 and 0xF0000. Each part has its own read-enable and write-enable bit. A part that reads from DRAM while its write enable is clear is write-protected: writes to it are discarded and do not reach the bus. Firmware uses this to copy a ROM into DRAM and then lock the copy. A separate output enables the external cache when two bits of a control register are both set.

Top module: `shadow_route_unit`

## Requirements
- R1: An I/O write to address 0x22 loads the index, using its low four bits. An I/O write to 0x24 stores the data in the register the index selects (16 registers, 0 to 15). An I/O read of 0x24 returns that register, a read of 0x22 returns the index zero-extended, and a read of any other address returns 0. `io_rdata` is 0 when `io_rd` is low.
- R2: After a synchronous reset every register and the index are zero, `cache_en` is 0, and every address in the window gives the external route for both reads and writes.
- R3: From 0xC0000 to 0xDFFFF, address bit 16 picks register 0x04 (clear) or 0x05 (set). Address bits 15:14 give the segment number k, and the segment uses bit 2k as its read enable and bit 2k+1 as its write enable.
- R4: Route codes are NONE=0, DRAM=1, EXT=2, DROP=3. `rd_route` is DRAM when the part's read enable is set and EXT when it is clear.
- R5: `wr_route` is DRAM when the write enable is set. With the write enable clear it is DROP if the read enable is set and EXT if not. DROP never appears on `rd_route`.
- R6: From 0xE0000 to 0xEFFFF, register 0x06 bit 0 is the read enable and bit 1 the write enable.
- R7: From 0xF0000 to 0xFFFFF, register 0x06 bit 2 is the read enable and bit 3 the write enable.
- R8: Addresses below 0xC0000 or above 0xFFFFF give NONE on all three route outputs.
- R9: `cache_en` is 1 exactly when register 0x02 has both bit 2 and bit 3 set.
- R10: Route outputs follow `mem_addr` in the same cycle. A data-port write changes the routes from the first cycle after the clock edge that captures it. A route output changes only when the address changes or an I/O write happened on the previous edge.
- R11: `acc_route` equals `wr_route` when `mem_we` is 1 and `rd_route` when `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| mem_addr | input | 24 | Memory access address |
| mem_we | input | 1 | 1 for a memory write, 0 for a read |
| rd_route | output | 2 | Route a read to this address would take |
| wr_route | output | 2 | Route a write to this address would take |
| acc_route | output | 2 | Route of the current access, chosen by mem_we |
| cache_en | output | 1 | External cache enable |

## Verification
The route outputs and `io_rdata` are combinational, so they are due in the same cycle as the address or read strobe. The bench drives inputs at the falling edge and samples one time unit later. A configuration write is held across one rising edge and its effect is checked only after the next falling edge, one register stage later. `cache_en` is registered state and is also checked one edge after the data-port write. A reference copy of the register file in the bench gives the expected routes for random and boundary addresses.

// File: rtl/shadow_pkg.sv
// Shared types for the shadow region decoder.
// Assumes two-bit route codes; the enum order is part of the port contract.
package shadow_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_DRAM = 2'd1,
        RT_EXT  = 2'd2,
        RT_DROP = 2'd3
    } route_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } part_ctl_t;

    // Read route from a part's enables.
    function automatic route_t rd_of(part_ctl_t c);
        return c.rd_en ? RT_DRAM : RT_EXT;
    endfunction

    // Write route: a part that is read from DRAM but not writable drops writes.
    function automatic route_t wr_of(part_ctl_t c);
        if (c.wr_en)
            return RT_DRAM;
        return c.rd_en ? RT_DROP : RT_EXT;
    endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
// Configuration register bank behind an index port and a data port.
// Holds NUM_REGS registers of DATA_W bits and hands the few control bytes the
// decoder needs straight out. Reads are combinational and side-effect free.
// Assumes a single I/O strobe per cycle; a write takes effect at the clock edge.
module shadow_cfg_regs #(
    parameter int          NUM_REGS   = 16,
    parameter int          DATA_W     = 8,
    parameter int          IO_AW      = 16,
    parameter logic [15:0] INDEX_PORT = 16'h0022,
    parameter logic [15:0] DATA_PORT  = 16'h0024,
    parameter int          CACHE_IDX  = 2,
    parameter int          SEG_LO_IDX = 4,
    parameter int          SEG_HI_IDX = 5,
    parameter int          TOP_IDX    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] cache_reg,
    output logic [DATA_W-1:0] seg_lo_reg,
    output logic [DATA_W-1:0] seg_hi_reg,
    output logic [DATA_W-1:0] top_reg
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [SEL_W-1:0]                 sel_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q;
    logic                             hit_index;
    logic                             hit_data;

    // Port decode for both strobes.
    assign hit_index = (io_addr == IO_AW'(INDEX_PORT));
    assign hit_data  = (io_addr == IO_AW'(DATA_PORT));

    // Index register: loaded from the low data bits on an index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (io_wr && hit_index)
            sel_q <= io_wdata[SEL_W-1:0];
    end

    // Register bank: one entry per index, written through the data port.
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[g] <= '0;
                else if (io_wr && hit_data && (sel_q == SEL_W'(g)))
                    bank_q[g] <= io_wdata;
            end
        end
    endgenerate

    // Read mux: data port gives the selected entry, index port the index.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (hit_data)
                io_rdata = bank_q[sel_q];
            else if (hit_index)
                io_rdata = DATA_W'(sel_q);
        end
    end

    assign cache_reg  = bank_q[CACHE_IDX];
    assign seg_lo_reg = bank_q[SEG_LO_IDX];
    assign seg_hi_reg = bank_q[SEG_HI_IDX];
    assign top_reg    = bank_q[TOP_IDX];

endmodule

// File: rtl/shadow_part_map.sv
// Unpacks control bytes into per-part read/write enables.
// Segments 0..SEGS_PER_REG-1 come from the low byte, the rest from the high
// byte, two bits per segment (read enable low, write enable high). The two
// large regions take consecutive bit pairs of the top byte.
module shadow_part_map
    import shadow_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_SEG = 8,
    parameter int NUM_BIG = 2
) (
    input  logic [DATA_W-1:0]  seg_lo_reg,
    input  logic [DATA_W-1:0]  seg_hi_reg,
    input  logic [DATA_W-1:0]  top_reg,
    output part_ctl_t          seg_ctl [NUM_SEG],
    output part_ctl_t          big_ctl [NUM_BIG]
);
    localparam int SEGS_PER_REG = DATA_W / 2;

    logic [2*SEGS_PER_REG-1:0][DATA_W-1:0] seg_src;
    logic unused_top;

    assign seg_src = {seg_hi_reg, seg_lo_reg};

    genvar s;
    generate
        // One bit pair per 16 KB segment.
        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            assign seg_ctl[s].rd_en = seg_src[s / SEGS_PER_REG][2 * (s % SEGS_PER_REG)];
            assign seg_ctl[s].wr_en = seg_src[s / SEGS_PER_REG][2 * (s % SEGS_PER_REG) + 1];
        end
        // One bit pair per 64 KB region.
        for (s = 0; s < NUM_BIG; s++) begin : g_big
            assign big_ctl[s].rd_en = top_reg[2 * s];
            assign big_ctl[s].wr_en = top_reg[2 * s + 1];
        end
    endgenerate

    assign unused_top = ^top_reg[DATA_W-1:2*NUM_BIG];

endmodule

// File: rtl/shadow_addr_decode.sv
// Maps a memory address to its part and produces read, write and access routes.
// Assumes a 1 MB real-mode map: segments cover 0xC0000-0xDFFFF in 16 KB steps,
// big regions cover 0xE0000-0xFFFFF in 64 KB steps. Purely combinational.
module shadow_addr_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_SEG = 8,
    parameter int NUM_BIG = 2
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  part_ctl_t         seg_ctl [NUM_SEG],
    input  part_ctl_t         big_ctl [NUM_BIG],
    output route_t            rd_route,
    output route_t            wr_route,
    output route_t            acc_route
);
    localparam int SEG_SH  = 14;
    localparam int BIG_SH  = 16;
    localparam int SEG_W   = $clog2(NUM_SEG);
    localparam int BIG_W   = (NUM_BIG > 1) ? $clog2(NUM_BIG) : 1;
    localparam logic [3:0] SEG_BASE_NIB = 4'hC;
    localparam logic [3:0] BIG_BASE_NIB = 4'hE;

    logic               above_map;
    logic [3:0]         nib;
    logic [SEG_W-1:0]   seg_sel;
    logic [BIG_W-1:0]   big_sel;
    logic               in_seg;
    logic               in_big;
    logic               unused_low;

    // Anything past the first megabyte is never claimed.
    generate
        if (ADDR_W > 20) begin : g_above
            assign above_map = |mem_addr[ADDR_W-1:20];
        end else begin : g_fit
            assign above_map = 1'b0;
        end
    endgenerate

    assign nib     = mem_addr[19:16];
    assign seg_sel = mem_addr[SEG_SH + SEG_W - 1:SEG_SH];
    assign big_sel = mem_addr[BIG_SH + BIG_W - 1:BIG_SH];
    assign unused_low = ^mem_addr[SEG_SH-1:0];

    // Window membership for each part family.
    assign in_seg = !above_map && (nib >= SEG_BASE_NIB) && (nib < BIG_BASE_NIB);
    assign in_big = !above_map && (nib >= BIG_BASE_NIB);

    // Route selection for the part the address falls in.
    always_comb begin
        rd_route = RT_NONE;
        wr_route = RT_NONE;
        if (in_seg) begin
            rd_route = rd_of(seg_ctl[seg_sel]);
            wr_route = wr_of(seg_ctl[seg_sel]);
        end else if (in_big) begin
            rd_route = rd_of(big_ctl[big_sel]);
            wr_route = wr_of(big_ctl[big_sel]);
        end
    end

    // Route of the access actually in flight.
    assign acc_route = mem_we ? wr_route : rd_route;

endmodule

// File: rtl/shadow_route_unit.sv
// Top of the shadow region decoder: I/O-reached configuration bank, part
// enable map and address decoder. Routes are combinational from the address
// and the current registers; configuration changes land on the clock edge.
module shadow_route_unit
    import shadow_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int IO_AW    = 16,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    output logic [1:0]        rd_route,
    output logic [1:0]        wr_route,
    output logic [1:0]        acc_route,
    output logic              cache_en
);
    localparam int NUM_SEG = 8;
    localparam int NUM_BIG = 2;
    localparam int CACHE_BIT_A = 2;
    localparam int CACHE_BIT_B = 3;

    logic [DATA_W-1:0] cache_reg;
    logic [DATA_W-1:0] seg_lo_reg;
    logic [DATA_W-1:0] seg_hi_reg;
    logic [DATA_W-1:0] top_reg;
    part_ctl_t         seg_ctl [NUM_SEG];
    part_ctl_t         big_ctl [NUM_BIG];
    route_t            rd_r, wr_r, acc_r;
    logic              unused_cache;

    shadow_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IO_AW    (IO_AW)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cache_reg  (cache_reg),
        .seg_lo_reg (seg_lo_reg),
        .seg_hi_reg (seg_hi_reg),
        .top_reg    (top_reg)
    );

    shadow_part_map #(
        .DATA_W  (DATA_W),
        .NUM_SEG (NUM_SEG),
        .NUM_BIG (NUM_BIG)
    ) map_i (
        .seg_lo_reg (seg_lo_reg),
        .seg_hi_reg (seg_hi_reg),
        .top_reg    (top_reg),
        .seg_ctl    (seg_ctl),
        .big_ctl    (big_ctl)
    );

    shadow_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_SEG (NUM_SEG),
        .NUM_BIG (NUM_BIG)
    ) dec_i (
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .seg_ctl   (seg_ctl),
        .big_ctl   (big_ctl),
        .rd_route  (rd_r),
        .wr_route  (wr_r),
        .acc_route (acc_r)
    );

    assign rd_route  = rd_r;
    assign wr_route  = wr_r;
    assign acc_route = acc_r;

    // Cache enable needs both control bits set.
    assign cache_en = cache_reg[CACHE_BIT_A] & cache_reg[CACHE_BIT_B];
    assign unused_cache = ^{cache_reg[DATA_W-1:CACHE_BIT_B+1], cache_reg[CACHE_BIT_A-1:0]};

endmodule

// File: rtl/shadow_route_checker.sv
// Port-level properties of the shadow region decoder, bound to the top.
module shadow_route_checker #(
    parameter int ADDR_W = 24,
    parameter int IO_AW  = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [IO_AW-1:0]  io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [1:0]        rd_route,
    input logic [1:0]        wr_route,
    input logic [1:0]        acc_route,
    input logic              cache_en
);
    localparam logic [IO_AW-1:0]  DPORT = IO_AW'(16'h0024);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(24'h0C0000);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(24'h0FFFFF);

    // R8: outside the window nothing is claimed.
    a_r8_outside_none: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < WIN_LO || mem_addr > WIN_HI) |-> (rd_route == 2'd0 && wr_route == 2'd0 && acc_route == 2'd0));

    // R5: a dropped write implies DRAM reads; reads never drop.
    a_r5_drop_needs_dram_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_route == 2'd3) |-> (rd_route == 2'd1));
    a_r5_rd_never_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_route != 2'd3);

    // R11: access route follows the qualifier.
    a_r11_acc_select: assert property (@(posedge clk) disable iff (!rst_n)
        acc_route == (mem_we ? wr_route : rd_route));

    // R4: any in-window address has a real route.
    a_r4_window_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >= WIN_LO && mem_addr <= WIN_HI) |-> (rd_route != 2'd0 && wr_route != 2'd0));

    // R10: routes move only with the address or after an I/O write.
    a_r10_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_route) || !$stable(wr_route)) |-> ($past(io_wr) || !$stable(mem_addr)));

    // R9: cache enable moves only after a data-port write.
    a_r9_cache_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cache_en) |-> $past(io_wr && io_addr == DPORT));

    // R1: a data-port write reads back on the next cycle.
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == DPORT && $past(io_wr && io_addr == DPORT && rst_n)) |-> io_rdata == $past(io_wdata));

    // R1: idle read strobe gives zero.
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

endmodule

bind shadow_route_unit shadow_route_checker #(
    .ADDR_W (ADDR_W),
    .IO_AW  (IO_AW),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .rd_route  (rd_route),
    .wr_route  (wr_route),
    .acc_route (acc_route),
    .cache_en  (cache_en)
);

// File: tb/shadow_route_unit_tb_top.sv
module shadow_route_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr, io_rd;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata, io_rdata;
    logic [23:0] mem_addr;
    logic        mem_we;
    logic [1:0]  rd_route, wr_route, acc_route;
    logic        cache_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] m_regs [16];
    logic [3:0] m_idx;

    always #2.5 clk = ~clk;

    shadow_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .rd_route(rd_route),
        .wr_route(wr_route), .acc_route(acc_route), .cache_en(cache_en)
    );

    // Reference route from the requirement text (codes NONE0 DRAM1 EXT2 DROP3).
    function automatic logic [1:0] ref_pair(input logic [23:0] a);
        logic [7:0] r;
        int k;
        if (a < 24'h0C0000 || a > 24'h0FFFFF) return 2'bxx;
        if (a < 24'h0E0000) begin
            r = a[16] ? m_regs[5] : m_regs[4];
            k = a[15:14];
            return {r[2*k+1], r[2*k]};
        end
        return a[16] ? m_regs[6][3:2] : m_regs[6][1:0];
    endfunction

    function automatic logic [1:0] exp_rd(input logic [23:0] a);
        logic [1:0] p = ref_pair(a);
        if (a < 24'h0C0000 || a > 24'h0FFFFF) return 2'd0;
        return p[0] ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [1:0] exp_wr(input logic [23:0] a);
        logic [1:0] p = ref_pair(a);
        if (a < 24'h0C0000 || a > 24'h0FFFFF) return 2'd0;
        if (p[1]) return 2'd1;
        return p[0] ? 2'd3 : 2'd2;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 16'h0022) m_idx = d[3:0];
        else if (a == 16'h0024) m_regs[m_idx] = d;
    endtask

    task automatic set_reg(input int i, input logic [7:0] d);
        io_write(16'h0022, 8'(i));
        io_write(16'h0024, d);
    endtask

    task automatic probe(input string req, input logic [23:0] a);
        mem_addr = a;
        mem_we = 1'b0;
        #1;
        check(req, {30'd0, rd_route}, {30'd0, exp_rd(a)});
        check(req, {30'd0, wr_route}, {30'd0, exp_wr(a)});
        check("R11", {30'd0, acc_route}, {30'd0, exp_rd(a)});
        mem_we = 1'b1;
        #1;
        check("R11", {30'd0, acc_route}, {30'd0, exp_wr(a)});
    endtask

    task automatic io_read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1;
        check(req, {24'd0, io_rdata}, {24'd0, exp});
        io_rd = 1'b0;
        #1;
        check("R1", {24'd0, io_rdata}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
        mem_addr = 0; mem_we = 0;
        m_idx = 0;
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state.
        check("R2", {31'd0, cache_en}, 32'd0);
        probe("R2", 24'h0C0000);
        probe("R2", 24'h0FFFF0);
        io_read_chk("R2", 16'h0024, 8'h00);

        // R8: outside the window.
        probe("R8", 24'h0BFFFF);
        probe("R8", 24'h100000);
        probe("R8", 24'h000000);

        // R3/R4/R5: segment bit pairs, one segment at a time.
        for (int s = 0; s < 8; s++) begin
            set_reg(s < 4 ? 4 : 5, 8'(8'b01 << (2 * (s % 4))));
            probe("R3", 24'h0C0000 + 24'(s) * 24'h4000);
            probe("R5", 24'h0C0000 + 24'(s) * 24'h4000 + 24'h3FFF);
            set_reg(s < 4 ? 4 : 5, 8'(8'b11 << (2 * (s % 4))));
            probe("R4", 24'h0C0000 + 24'(s) * 24'h4000 + 24'h2000);
            set_reg(s < 4 ? 4 : 5, 8'(8'b10 << (2 * (s % 4))));
            probe("R5", 24'h0C0000 + 24'(s) * 24'h4000 + 24'h10);
            set_reg(s < 4 ? 4 : 5, 8'h00);
        end

        // R6/R7: the two large regions, all four enable combinations.
        for (int v = 0; v < 16; v++) begin
            set_reg(6, 8'(v));
            probe("R6", 24'h0E0000);
            probe("R6", 24'h0EFFFF);
            probe("R7", 24'h0F0000);
            probe("R7", 24'h0FFFFF);
        end

        // R10: change lands exactly one edge after the data-port write.
        set_reg(6, 8'h00);
        io_write(16'h0022, 8'h06);
        mem_addr = 24'h0F8000; mem_we = 1'b0;
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'h0024; io_wdata = 8'h04;
        #1;
        check("R10", {30'd0, rd_route}, 32'd2);
        @(negedge clk);
        io_wr = 1'b0;
        m_regs[6] = 8'h04;
        #1;
        check("R10", {30'd0, rd_route}, 32'd1);

        // R9: cache enable needs both bits.
        set_reg(2, 8'h04); #1; check("R9", {31'd0, cache_en}, 32'd0);
        set_reg(2, 8'h08); #1; check("R9", {31'd0, cache_en}, 32'd0);
        set_reg(2, 8'h0C); #1; check("R9", {31'd0, cache_en}, 32'd1);
        set_reg(2, 8'hF3); #1; check("R9", {31'd0, cache_en}, 32'd0);

        // R1: index/data port behaviour across all registers.
        for (int i = 0; i < 16; i++) set_reg(i, 8'(8'h5A ^ (i * 17)));
        for (int i = 0; i < 16; i++) begin
            io_write(16'h0022, 8'(i) | 8'hF0);
            io_read_chk("R1", 16'h0024, m_regs[i]);
            io_read_chk("R1", 16'h0022, 8'(i));
        end
        io_read_chk("R1", 16'h0030, 8'h00);
        // R1: write to an unrelated port leaves the selected register alone.
        io_write(16'h0022, 8'h03);
        io_write(16'h0025, 8'hEE);
        io_read_chk("R1", 16'h0024, m_regs[3]);

        // Random configuration and address mix.
        for (int n = 0; n < 400; n++) begin
            int pick = $urandom_range(0, 3);
            set_reg(pick == 0 ? 4 : pick == 1 ? 5 : pick == 2 ? 6 : 2, 8'($urandom));
            for (int q = 0; q < 4; q++) begin
                logic [23:0] a = 24'($urandom_range(24'h0B0000, 24'h110000));
                probe("R4", a);
            end
            #1;
            check("R9", {31'd0, cache_en}, {31'd0, m_regs[2][2] & m_regs[2][3]});
        end

        // R2: a second reset clears everything again.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        m_idx = 0;
        #1;
        check("R2", {31'd0, cache_en}, 32'd0);
        probe("R2", 24'h0D4000);
        probe("R2", 24'h0E8000);
        io_read_chk("R2", 16'h0022, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule